// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface

This block models the control side of an asynchronous parallel NOR flash device, sampled by a system clock. Four bus pins (chip select, output enable, write enable, hardware reset) decode into read, write, standby, output-disable and reset operations. A command state machine interprets write cycles as unlock and command sequences. It moves the device between array read, autoselect code read, program, sector or chip erase, status read while busy, and an unlock bypass mode that shortens programming.

The storage is a small internal word array split into equal sectors. Programming can only clear bits. Erasing sets whole sectors to all ones. Each operation keeps the device busy for a fixed number of clocks. During that time reads return a polling byte, not array data. A width pin selects 16-bit word access or 8-bit byte access. In byte mode the top data pin becomes the least significant address input.

Top module: `nor_cmd_if`

## Requirements
- R1: After `por_n` is released the mode is array read and every word reads 16'hFFFF. Reading array data needs no prior command.
- R2: A read is `ce_n`=0, `oe_n`=0, `we_n`=1 with `rst_pin_n`=1. A write is `ce_n`=0, `we_n`=0, `oe_n`=1. During a write `dq_oe` is 0.
- R3: With `ce_n`=1, with `oe_n`=1, or with `rst_pin_n`=0, every bit of `dq_oe` is 0 (high impedance).
- R4: Programming takes four writes: 8'hAA at word address 11'h555, 8'h55 at 11'h2AA, 8'hA0 at 11'h555, then the data at the target. The target becomes old AND data.
- R5: For `BUSY_CYC` clocks after the final program write, reads return 16'h0080 when written bit 7 was 0, or 16'h0000 when it was 1 (bit 7 is the complement; all other bits are 0). Writes during this time are ignored.
- R6: 8'hAA/555, 8'h55/2AA, 8'h90/555 enters autoselect. Reads then return {8'h00, code}: code is `MFG_ID` when addr[1:0]=0, `DEV_ID` when addr[1:0]=1, and 0 otherwise. A write of 8'hF0 at any address returns to array read.
- R7: 8'hAA/555, 8'h55/2AA, 8'h20/555 enters unlock bypass. There, 8'hA0 at any address followed by the data programs in two writes, and reads return array data. 8'h90 followed by 8'hF0 leaves to array read.
- R8: 8'hAA/555, 8'h55/2AA, 8'h80/555, 8'hAA/555, 8'h55/2AA, then 8'h30 at an address erases that sector to 16'hFFFF. The sector is the top `SEC_W` bits of the word index addr[MEM_AW-1:0]. Erase starts once `ERS_WIN` clocks pass with no further write, and other sectors are unchanged. Reads during the window and erase return 16'h0000.
- R9: Each further 8'h30 written inside the window adds that sector and restarts the window.
- R10: 8'h10 at 11'h555 as the sixth erase write sets every word to 16'hFFFF.
- R11: A write that does not match the expected step of a sequence returns the mode to array read. A following partial sequence then programs nothing.
- R12: With `byte_n`=0, `dq_i[15]` selects the byte (1 = upper) of word `addr`. A read drives `dq_oe`=16'h00FF with the byte on `dq_o[7:0]`, and a program changes only the selected byte.
- R13: `rst_pin_n`=0 returns the mode to array read from any mode. Stored data is kept.
- R14: One low period of `we_n` is one command write, however many clocks it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| por_n | input | 1 | Power-up reset, active low; erases the array |
| rst_pin_n | input | 1 | Device hardware reset pin, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| byte_n | input | 1 | 1 = word access, 0 = byte access |
| addr | input | AW | Word address |
| dq_i | input | 16 | Data in; bit 15 is the byte select in byte mode |
| dq_o | output | 16 | Data out |
| dq_oe | output | 16 | Per-bit output enable; 0 means high impedance |

## Verification
The hardest state to reach from the pins is the multi-sector erase window. A second sector command has to land after the six-write erase preamble but before the idle window expires. The bench spaces its writes two clocks apart, well inside the window, and then checks every word against a model. Writes landing while the device is busy are also hard to see, because their only effect is that nothing happens. The stimulus places the first unlock write inside the busy period and finishes the sequence after it. A later read then shows that no word changed.

// File: rtl/nor_pkg.sv
package nor_pkg;
    typedef enum logic [3:0] {
        M_READ, M_U1, M_U2, M_PROG, M_AUTO, M_ERS3, M_ERS4, M_ERS5,
        M_ERSWIN, M_BUSY, M_BYP, M_BYPPG, M_BYPRST
    } mode_e;

    typedef enum logic [1:0] {SRC_ARRAY, SRC_AUTO, SRC_STATUS} src_e;

    localparam logic [7:0] CMD_UNLK1  = 8'hAA;
    localparam logic [7:0] CMD_UNLK2  = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_AUTO   = 8'h90;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_BYPASS = 8'h20;
    localparam logic [7:0] CMD_SECT   = 8'h30;
    localparam logic [7:0] CMD_CHIP   = 8'h10;
    localparam logic [7:0] CMD_EXIT   = 8'hF0;

    localparam logic [10:0] ADR_A = 11'h555;
    localparam logic [10:0] ADR_B = 11'h2AA;
endpackage

// File: rtl/nor_bus_decode.sv
module nor_bus_decode (
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic        rst_pin_n,
    input  logic        byte_n,
    output logic        rd_op,
    output logic        wr_op,
    output logic [15:0] oe_mask
);
    always_comb begin
        rd_op   = rst_pin_n && !ce_n && !oe_n && we_n;
        wr_op   = rst_pin_n && !ce_n && !we_n && oe_n;
        oe_mask = '0;
        if (rd_op) begin
            oe_mask = byte_n ? 16'hFFFF : 16'h00FF;
        end
    end
endmodule

// File: rtl/nor_read_mux.sv
module nor_read_mux
    import nor_pkg::*;
#(
    parameter logic [7:0] MFG_ID = 8'h3C,
    parameter logic [7:0] DEV_ID = 8'hB7
) (
    input  src_e        src,
    input  logic [15:0] rd_word,
    input  logic [7:0]  stat,
    input  logic [1:0]  code_sel,
    input  logic        sel_hi,
    input  logic        byte_n,
    input  logic [15:0] oe_mask,
    output logic [15:0] dq_o,
    output logic [15:0] dq_oe
);
    logic [7:0]  code;
    logic [15:0] word;

    always_comb begin
        unique case (code_sel)
            2'd0:    code = MFG_ID;
            2'd1:    code = DEV_ID;
            default: code = 8'h00;
        endcase
        unique case (src)
            SRC_AUTO:   word = {8'h00, code};
            SRC_STATUS: word = {8'h00, stat};
            default: begin
                if (byte_n)      word = rd_word;
                else if (sel_hi) word = {8'h00, rd_word[15:8]};
                else             word = {8'h00, rd_word[7:0]};
            end
        endcase
        dq_o  = word & oe_mask;
        dq_oe = oe_mask;
    end
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_pkg::*;
#(
    parameter int AW       = 11,
    parameter int MEM_AW   = 5,
    parameter int SEC_W    = 2,
    parameter int BUSY_CYC = 6,
    parameter int ERS_WIN  = 5
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          rst_pin_n,
    input  logic          wr_op,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   dq_i,
    input  logic          byte_n,
    output src_e          src,
    output logic [7:0]    stat,
    output logic [15:0]   rd_word
);
    localparam int DEPTH  = 1 << MEM_AW;
    localparam int NSEC   = 1 << SEC_W;
    localparam int SEC_SH = MEM_AW - SEC_W;
    localparam int MAXC   = (BUSY_CYC > ERS_WIN) ? BUSY_CYC : ERS_WIN;
    localparam int CW     = $clog2(MAXC + 1);

    typedef struct packed {
        mode_e                  mode;
        logic [CW-1:0]          cnt;
        logic [NSEC-1:0]        smask;
        logic                   poll;
        logic                   ret_byp;
        logic                   wr_prev;
        logic [DEPTH-1:0][15:0] mem;
    } st_t;

    st_t s_q, s_d;

    logic              wr_edge;
    logic [MEM_AW-1:0] idx;
    logic [SEC_W-1:0]  sec;
    logic [7:0]        cd;
    logic              at_a, at_b;
    logic [15:0]       old_w, prog_w;

    always_comb begin
        wr_edge = wr_op && !s_q.wr_prev;
        idx     = addr[MEM_AW-1:0];
        sec     = idx[MEM_AW-1 -: SEC_W];
        cd      = dq_i[7:0];
        at_a    = (addr == AW'(ADR_A));
        at_b    = (addr == AW'(ADR_B));
        old_w   = s_q.mem[idx];
        if (byte_n)       prog_w = old_w & dq_i;
        else if (dq_i[15]) prog_w = {old_w[15:8] & cd, old_w[7:0]};
        else              prog_w = {old_w[15:8], old_w[7:0] & cd};
    end

    always_comb begin
        s_d         = s_q;
        s_d.wr_prev = wr_op;
        if (!rst_pin_n) begin
            s_d.mode  = M_READ;
            s_d.cnt   = '0;
            s_d.smask = '0;
        end else begin
            unique case (s_q.mode)
                M_READ: if (wr_edge && at_a && cd == CMD_UNLK1) s_d.mode = M_U1;
                M_U1: if (wr_edge) s_d.mode = (at_b && cd == CMD_UNLK2) ? M_U2 : M_READ;
                M_U2: if (wr_edge) begin
                    s_d.mode = M_READ;
                    if (at_a) begin
                        unique case (cd)
                            CMD_PROG:   s_d.mode = M_PROG;
                            CMD_AUTO:   s_d.mode = M_AUTO;
                            CMD_ERASE:  s_d.mode = M_ERS3;
                            CMD_BYPASS: s_d.mode = M_BYP;
                            default:    s_d.mode = M_READ;
                        endcase
                    end
                end
                M_PROG, M_BYPPG: if (wr_edge) begin
                    s_d.mem[idx] = prog_w;
                    s_d.poll     = ~dq_i[7];
                    s_d.ret_byp  = (s_q.mode == M_BYPPG);
                    s_d.mode     = M_BUSY;
                    s_d.cnt      = CW'(BUSY_CYC - 1);
                end
                M_BUSY: begin
                    if (s_q.cnt == '0) s_d.mode = s_q.ret_byp ? M_BYP : M_READ;
                    else               s_d.cnt  = s_q.cnt - 1'b1;
                end
                M_AUTO: if (wr_edge && cd == CMD_EXIT) s_d.mode = M_READ;
                M_ERS3: if (wr_edge) s_d.mode = (at_a && cd == CMD_UNLK1) ? M_ERS4 : M_READ;
                M_ERS4: if (wr_edge) s_d.mode = (at_b && cd == CMD_UNLK2) ? M_ERS5 : M_READ;
                M_ERS5: if (wr_edge) begin
                    s_d.poll    = 1'b0;
                    s_d.ret_byp = 1'b0;
                    if (cd == CMD_SECT) begin
                        s_d.smask = NSEC'(1) << sec;
                        s_d.mode  = M_ERSWIN;
                        s_d.cnt   = CW'(ERS_WIN - 1);
                    end else if (cd == CMD_CHIP && at_a) begin
                        s_d.mem  = '1;
                        s_d.mode = M_BUSY;
                        s_d.cnt  = CW'(BUSY_CYC - 1);
                    end else begin
                        s_d.mode = M_READ;
                    end
                end
                M_ERSWIN: begin
                    if (wr_edge) begin
                        if (cd == CMD_SECT) begin
                            s_d.smask = s_q.smask | (NSEC'(1) << sec);
                            s_d.cnt   = CW'(ERS_WIN - 1);
                        end else begin
                            s_d.smask = '0;
                            s_d.mode  = M_READ;
                        end
                    end else if (s_q.cnt == '0) begin
                        for (int i = 0; i < DEPTH; i++) begin
                            if (s_q.smask[SEC_W'(i >> SEC_SH)]) s_d.mem[i] = '1;
                        end
                        s_d.smask = '0;
                        s_d.mode  = M_BUSY;
                        s_d.cnt   = CW'(BUSY_CYC - 1);
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
                M_BYP: if (wr_edge) begin
                    if (cd == CMD_PROG)      s_d.mode = M_BYPPG;
                    else if (cd == CMD_AUTO) s_d.mode = M_BYPRST;
                end
                M_BYPRST: if (wr_edge) s_d.mode = (cd == CMD_EXIT) ? M_READ : M_BYP;
                default: s_d.mode = M_READ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            s_q     <= '0;
            s_q.mem <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_word = s_q.mem[idx];
        stat    = {s_q.poll, 7'b0};
        if (s_q.mode == M_BUSY || s_q.mode == M_ERSWIN) src = SRC_STATUS;
        else if (s_q.mode == M_AUTO)                    src = SRC_AUTO;
        else                                            src = SRC_ARRAY;
    end

    p_reset_pin_r13: assert property (@(posedge clk) disable iff (!por_n)
        !rst_pin_n |=> s_q.mode == M_READ);
    p_busy_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
        (rst_pin_n && s_q.mode == M_BUSY && s_q.cnt != '0) |=> s_q.mode == M_BUSY);
    p_busy_nowrite_r5: assert property (@(posedge clk) disable iff (!por_n)
        (s_q.mode == M_BUSY) |=> $stable(s_q.mem));
    p_window_mask_r9: assert property (@(posedge clk) disable iff (!por_n)
        (s_q.mode == M_ERSWIN) |-> s_q.smask != '0);
endmodule

// File: rtl/nor_cmd_if.sv
module nor_cmd_if
    import nor_pkg::*;
#(
    parameter int         AW       = 11,
    parameter int         MEM_AW   = 5,
    parameter int         SEC_W    = 2,
    parameter int         BUSY_CYC = 6,
    parameter int         ERS_WIN  = 5,
    parameter logic [7:0] MFG_ID   = 8'h3C,
    parameter logic [7:0] DEV_ID   = 8'hB7
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          rst_pin_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          byte_n,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   dq_i,
    output logic [15:0]   dq_o,
    output logic [15:0]   dq_oe
);
    logic        rd_op, wr_op;
    logic [15:0] oe_mask;
    src_e        src;
    logic [7:0]  stat;
    logic [15:0] rd_word;

    nor_bus_decode i_dec (
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rst_pin_n(rst_pin_n),
        .byte_n(byte_n), .rd_op(rd_op), .wr_op(wr_op), .oe_mask(oe_mask)
    );

    nor_cmd_fsm #(
        .AW(AW), .MEM_AW(MEM_AW), .SEC_W(SEC_W),
        .BUSY_CYC(BUSY_CYC), .ERS_WIN(ERS_WIN)
    ) i_fsm (
        .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .wr_op(wr_op),
        .addr(addr), .dq_i(dq_i), .byte_n(byte_n),
        .src(src), .stat(stat), .rd_word(rd_word)
    );

    nor_read_mux #(.MFG_ID(MFG_ID), .DEV_ID(DEV_ID)) i_mux (
        .src(src), .rd_word(rd_word), .stat(stat), .code_sel(addr[1:0]),
        .sel_hi(dq_i[15]), .byte_n(byte_n), .oe_mask(oe_mask),
        .dq_o(dq_o), .dq_oe(dq_oe)
    );

    p_hiz_r3: assert property (@(posedge clk) disable iff (!por_n)
        (ce_n || oe_n || !rst_pin_n) |-> dq_oe == '0);
    p_byte_oe_r12: assert property (@(posedge clk) disable iff (!por_n)
        (!byte_n && rd_op) |-> (dq_oe == 16'h00FF && dq_o[15:8] == 8'h00));
    p_write_quiet_r2: assert property (@(posedge clk) disable iff (!por_n)
        wr_op |-> dq_oe == '0);
endmodule

// File: tb/test_nor_cmd_if.sv
`timescale 1ns/1ps
module test_nor_cmd_if;
    localparam int CLK_P    = 10;
    localparam int AW       = 11;
    localparam int MEM_AW   = 5;
    localparam int SEC_W    = 2;
    localparam int BUSY_CYC = 6;
    localparam int ERS_WIN  = 5;
    localparam int DEPTH    = 1 << MEM_AW;
    localparam int SEC_SH   = MEM_AW - SEC_W;

    logic clk = 0, por_n = 0, rst_pin_n = 1, ce_n = 1, oe_n = 1, we_n = 1, byte_n = 1;
    logic [AW-1:0] addr = '0;
    logic [15:0] dq_i = '0, dq_o, dq_oe;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [15:0] ref_mem [DEPTH];

    always #(CLK_P/2) clk = ~clk;

    nor_cmd_if i_nor_cmd_if (
        .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .ce_n(ce_n),
        .oe_n(oe_n), .we_n(we_n), .byte_n(byte_n), .addr(addr),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [10:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; dq_i = d; ce_n = 0; oe_n = 1; we_n = 0;
        @(negedge clk);
        we_n = 1; ce_n = 1;
    endtask

    task automatic rd(input logic [10:0] a, input logic b, output logic [15:0] d, output logic [15:0] e);
        @(negedge clk);
        addr = a; dq_i = {b, 15'b0}; ce_n = 0; oe_n = 0; we_n = 1;
        #1;
        d = dq_o; e = dq_oe;
        ce_n = 1; oe_n = 1;
    endtask

    task automatic unlock();
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
    endtask

    task automatic prog(input logic [10:0] a, input logic [15:0] d);
        unlock();
        wr(11'h555, 16'h00A0);
        wr(a, d);
        idle(BUSY_CYC + 2);
    endtask

    task automatic erase_pre();
        unlock();
        wr(11'h555, 16'h0080);
        unlock();
    endtask

    task automatic check_all(input string tag);
        logic [15:0] d, e;
        for (int i = 0; i < DEPTH; i++) begin
            rd(11'(i), 1'b0, d, e);
            chk(tag, d, ref_mem[i]);
        end
    endtask

    function automatic logic [15:0] pat(input int i, input logic [15:0] k);
        return 16'(i * 40503) ^ k;
    endfunction

    initial begin
        logic [15:0] d, e;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 16'hFFFF;
        idle(3);
        por_n = 1;
        idle(2);

        // R1: erased after power-up, array read without command
        check_all("R1 word sweep");
        byte_n = 0;
        for (int i = 0; i < 2 * DEPTH; i++) begin
            rd(11'(i >> 1), i[0], d, e);
            chk("R1 byte sweep", d, 16'h00FF);
        end
        byte_n = 1;

        // R2/R3: bus decode and high impedance
        rd(11'd0, 1'b0, d, e);
        chk("R2 read oe", e, 16'hFFFF);
        @(negedge clk); ce_n = 1; oe_n = 0; #1; chk("R3 standby", dq_oe, 16'h0000);
        ce_n = 0; oe_n = 1; #1; chk("R3 output disable", dq_oe, 16'h0000);
        oe_n = 0; rst_pin_n = 0; #1; chk("R3 reset pin", dq_oe, 16'h0000);
        rst_pin_n = 1; oe_n = 1; we_n = 0; #1; chk("R2 write oe", dq_oe, 16'h0000);
        @(negedge clk); we_n = 1; ce_n = 1;
        idle(2);

        // R4: program sweep, then second pass ANDs
        for (int i = 0; i < DEPTH; i++) begin
            prog(11'(i), pat(i, 16'hC3A5));
            ref_mem[i] &= pat(i, 16'hC3A5);
        end
        check_all("R4 first pass");
        for (int i = 0; i < DEPTH; i++) begin
            prog(11'(i), pat(i, 16'h5AF7) | 16'h0F0F);
            ref_mem[i] &= pat(i, 16'h5AF7) | 16'h0F0F;
        end
        check_all("R4 and pass");

        // R5: status while busy, writes ignored while busy
        unlock(); wr(11'h555, 16'h00A0); wr(11'd5, 16'h1234);
        ref_mem[5] &= 16'h1234;
        rd(11'd5, 1'b0, d, e);
        chk("R5 status bit7 clear", d, 16'h0080);
        wr(11'h555, 16'h00AA);
        idle(BUSY_CYC + 2);
        wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0); wr(11'd6, 16'h0000);
        idle(BUSY_CYC + 2);
        rd(11'd6, 1'b0, d, e); chk("R5 write in busy ignored", d, ref_mem[6]);
        rd(11'd5, 1'b0, d, e); chk("R5 program done", d, ref_mem[5]);
        unlock(); wr(11'h555, 16'h00A0); wr(11'd4, 16'h0080);
        ref_mem[4] &= 16'h0080;
        rd(11'd4, 1'b0, d, e);
        chk("R5 status bit7 set", d, 16'h0000);
        idle(BUSY_CYC + 2);

        // R6: autoselect codes and exit
        unlock(); wr(11'h555, 16'h0090);
        rd(11'd0, 1'b0, d, e); chk("R6 mfg", d, 16'h003C);
        rd(11'd1, 1'b0, d, e); chk("R6 dev", d, 16'h00B7);
        rd(11'd2, 1'b0, d, e); chk("R6 zero", d, 16'h0000);
        wr(11'd9, 16'h0000);
        rd(11'd4, 1'b0, d, e); chk("R6 still auto", d, 16'h003C);
        wr(11'd7, 16'h00F0);
        rd(11'd0, 1'b0, d, e); chk("R6 exit", d, ref_mem[0]);

        // R7: unlock bypass
        unlock(); wr(11'h555, 16'h0020);
        wr(11'd3, 16'h00A0); wr(11'd10, 16'h00FF);
        ref_mem[10] &= 16'h00FF;
        idle(BUSY_CYC + 2);
        wr(11'd3, 16'h00A0); wr(11'd11, 16'hF000);
        ref_mem[11] &= 16'hF000;
        idle(BUSY_CYC + 2);
        rd(11'd10, 1'b0, d, e); chk("R7 bypass prog a", d, ref_mem[10]);
        rd(11'd11, 1'b0, d, e); chk("R7 bypass prog b", d, ref_mem[11]);
        wr(11'd0, 16'h0090); wr(11'd0, 16'h00F0);
        wr(11'h555, 16'h00A0); wr(11'd7, 16'h0000);
        idle(BUSY_CYC + 2);
        rd(11'd7, 1'b0, d, e); chk("R7 exited bypass", d, ref_mem[7]);

        // R11: broken sequence returns to read
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0012);
        wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0); wr(11'd8, 16'h0000);
        idle(BUSY_CYC + 2);
        rd(11'd8, 1'b0, d, e); chk("R11 no program", d, ref_mem[8]);

        // R12: byte mode
        byte_n = 0;
        unlock(); wr(11'h555, 16'h00A0); wr(11'd12, 16'h8000 | 16'h005A);
        ref_mem[12][15:8] &= 8'h5A;
        idle(BUSY_CYC + 2);
        unlock(); wr(11'h555, 16'h00A0); wr(11'd13, 16'h003C);
        ref_mem[13][7:0] &= 8'h3C;
        idle(BUSY_CYC + 2);
        rd(11'd12, 1'b1, d, e); chk("R12 hi byte", d, {8'h00, ref_mem[12][15:8]});
        chk("R12 oe mask", e, 16'h00FF);
        rd(11'd12, 1'b0, d, e); chk("R12 lo byte", d, {8'h00, ref_mem[12][7:0]});
        byte_n = 1;
        rd(11'd12, 1'b0, d, e); chk("R12 word after hi", d, ref_mem[12]);
        rd(11'd13, 1'b0, d, e); chk("R12 word after lo", d, ref_mem[13]);

        // R13: reset pin leaves autoselect, keeps data
        unlock(); wr(11'h555, 16'h0090);
        @(negedge clk); rst_pin_n = 0;
        idle(2); rst_pin_n = 1;
        rd(11'd16, 1'b0, d, e); chk("R13 array after reset", d, ref_mem[16]);

        // R14: long write pulse counts once
        @(negedge clk); addr = 11'h555; dq_i = 16'h00AA; ce_n = 0; oe_n = 1; we_n = 0;
        idle(3); we_n = 1; ce_n = 1;
        wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0); wr(11'd17, 16'h0000);
        ref_mem[17] = 16'h0000;
        idle(BUSY_CYC + 2);
        rd(11'd17, 1'b0, d, e); chk("R14 held write", d, ref_mem[17]);

        // R8: single sector erase
        erase_pre(); wr(11'd9, 16'h0030);
        rd(11'd9, 1'b0, d, e); chk("R8 window status", d, 16'h0000);
        idle(ERS_WIN + BUSY_CYC + 4);
        for (int i = 0; i < DEPTH; i++) if ((i >> SEC_SH) == 1) ref_mem[i] = 16'hFFFF;
        check_all("R8 sector erase");

        // R9: two sectors in one window
        erase_pre(); wr(11'd0, 16'h0030); wr(11'd30, 16'h0030);
        idle(ERS_WIN + BUSY_CYC + 4);
        for (int i = 0; i < DEPTH; i++)
            if ((i >> SEC_SH) == 0 || (i >> SEC_SH) == 3) ref_mem[i] = 16'hFFFF;
        check_all("R9 multi sector");

        // R10: chip erase
        erase_pre(); wr(11'h555, 16'h0010);
        idle(BUSY_CYC + 2);
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 16'hFFFF;
        check_all("R10 chip erase");

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule